// File: doc/BRIEF.md
# SPI Master Serial Clock Generator

This block derives the serial clock of an SPI master from the system clock. An 8-bit divisor register sets the rate. Each half-period of the serial clock lasts exactly as many system clocks as the divisor value, so one full serial clock period spans twice the divisor. Divisor values below two are not treated as fast rates. They switch the generator off: the serial clock stays at its idle level and no transfer can begin.

Software writes the divisor with a write strobe. It arms the master with an enable strobe and sets the idle level with a clock-polarity input. A transfer is requested with a level request and a bit count. The block acknowledges the request, produces two clock edges for every bit, and returns the clock to its idle level. It then raises a one-cycle done pulse and clears the enable bit on its own. A mode-fault input shuts the generator down at once. The divisor may be rewritten during a transfer. The new value applies from the next half-period onward, so no shortened pulse is produced.

Top module: `sckgen_top`

## Requirements
- R1: After reset the enable output is 0, the serial clock is low, done and acknowledge are 0, and the divisor holds 4. With that divisor, a transfer started without any divisor write has half-periods of 4 clocks.
- R2: Every half-period of the serial clock lasts exactly the divisor value in system clocks. The first edge comes that many clocks after the cycle in which the acknowledge is visible.
- R3: A transfer of N bits (N from 1 to 31) produces exactly 2N serial clock edges and then leaves the clock at the idle level. The done output is high for one cycle, in the same cycle as the last edge.
- R4: The enable output drops to 0 in the same cycle as the done pulse.
- R5: An enable strobe while the divisor is 0 or 1 has no effect. The enable output stays 0, requests are not acknowledged, and the serial clock does not toggle.
- R6: A divisor write during a transfer leaves the half-period already under way unchanged. Every half-period that starts after the write uses the new value.
- R7: A mode-fault input that is high for one cycle clears the enable output and aborts any transfer. The serial clock is back at the idle level in the next cycle, and no done pulse follows.
- R8: While no transfer runs, the serial clock follows the clock-polarity input with one cycle of delay.
- R9: A request is acknowledged with a one-cycle pulse only while the enable output is 1, the generator is idle and the bit count is nonzero. A request with a bit count of 0 is never acknowledged and leaves the enable output at 1.
- R10: Writing a divisor of 0 or 1 during a transfer aborts it. Two cycles after the write strobe, the enable output is 0 and the serial clock is at the idle level, with no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_wr | input | 1 | Divisor write strobe |
| div_wdata | input | 8 | Divisor value to write |
| en_set | input | 1 | Strobe that sets the enable bit |
| cpol | input | 1 | Idle level of the serial clock |
| mode_fault | input | 1 | Fault input that forces shutdown |
| xfer_req | input | 1 | Transfer request level |
| xfer_bits | input | 5 | Number of bits in the requested transfer |
| xfer_ack | output | 1 | One-cycle pulse when a request is accepted |
| enable | output | 1 | Enable bit |
| sck | output | 1 | Serial clock |
| done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
A wrong half-period count or a wrong reload value shows up at the serial clock output on the very next edge, as an interval that differs from the divisor. An edge counter that is off by one shows up when the transfer ends: the edge total is wrong, the clock is left on the active level, or the done pulse and the enable drop come at the wrong edge. A shutdown path that misbehaves is seen within one or two cycles of the fault or the illegal write, through the enable bit and the idle level. The bench times each edge in clock cycles and compares it with the divisor in force when that half-period began.

// File: rtl/sckgen_pkg.sv
`timescale 1ns/1ps
package sckgen_pkg;
    localparam int          DIV_W     = 8;
    localparam int          BITS_W    = 5;
    localparam int          EDGE_W    = BITS_W + 1;
    localparam logic [DIV_W-1:0] DIV_RESET = 8'd4;
    localparam logic [DIV_W-1:0] DIV_MIN   = 8'd2;

    function automatic logic div_is_legal(input logic [DIV_W-1:0] v);
        return v >= DIV_MIN;
    endfunction
endpackage

// File: rtl/sckgen_divreg.sv
`timescale 1ns/1ps
module sckgen_divreg
    import sckgen_pkg::*;
#(
    parameter int                 W     = DIV_W,
    parameter logic [W-1:0]       RST_V = DIV_RESET
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] div,
    output logic         legal
);
    typedef struct packed {
        logic [W-1:0] val;
        logic         ok;
    } divreg_t;

    divreg_t d, q;

    always_comb begin
        d = q;
        if (wr) begin
            d.val = wdata;
            d.ok  = wdata >= W'(DIV_MIN);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.val <= RST_V;
            q.ok  <= RST_V >= W'(DIV_MIN);
        end else begin
            q <= d;
        end
    end

    assign div   = q.val;
    assign legal = q.ok;

    // a write of an illegal value must be reflected in the legal flag next cycle (R5)
    assert_legal_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (legal == (div >= W'(DIV_MIN))));
endmodule

// File: rtl/sckgen_halfcnt.sv
`timescale 1ns/1ps
module sckgen_halfcnt
    import sckgen_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         run,
    input  logic [W-1:0] div,
    output logic         tick
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } halfcnt_t;

    halfcnt_t d, q;

    assign tick = run && (q.cnt == W'(1));

    always_comb begin
        d = q;
        if (load) begin
            d.cnt = div;
        end else if (run) begin
            if (tick) d.cnt = div;
            else      d.cnt = q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q.cnt <= '0;
        else        q <= d;
    end

    // a running half-period counter never sits at zero (R2)
    assert_cnt_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && $past(load)) |-> (q.cnt != '0));
endmodule

// File: rtl/sckgen_ctrl.sv
`timescale 1ns/1ps
module sckgen_ctrl
    import sckgen_pkg::*;
#(
    parameter int BW = BITS_W,
    localparam int EW = BW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_set,
    input  logic          legal,
    input  logic          cpol,
    input  logic          mode_fault,
    input  logic          req,
    input  logic [BW-1:0] bits,
    input  logic          tick,
    output logic          start,
    output logic          busy,
    output logic          en,
    output logic          sck,
    output logic          ack,
    output logic          done
);
    typedef struct packed {
        logic          en;
        logic          busy;
        logic          sck;
        logic          ack;
        logic          done;
        logic [EW-1:0] edges;
    } ctrl_t;

    ctrl_t d, q;
    logic  seen_q;

    always_comb begin
        d      = q;
        d.ack  = 1'b0;
        d.done = 1'b0;
        start  = 1'b0;
        if (!q.busy) d.sck = cpol;
        if (en_set && legal) d.en = 1'b1;
        if (!legal) d.en = 1'b0;

        if (mode_fault) begin
            d.en   = 1'b0;
            d.busy = 1'b0;
            d.sck  = cpol;
        end else if (q.busy) begin
            if (!legal) begin
                d.busy = 1'b0;
                d.sck  = cpol;
            end else if (tick) begin
                d.sck   = ~q.sck;
                d.edges = q.edges - EW'(1);
                if (q.edges == EW'(1)) begin
                    d.busy = 1'b0;
                    d.en   = 1'b0;
                    d.done = 1'b1;
                end
            end
        end else if (q.en && legal && req && (bits != '0)) begin
            start   = 1'b1;
            d.busy  = 1'b1;
            d.ack   = 1'b1;
            d.sck   = q.sck;
            d.edges = {bits, 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            seen_q <= 1'b0;
        end else begin
            q      <= d;
            seen_q <= 1'b1;
        end
    end

    assign busy = q.busy;
    assign en   = q.en;
    assign sck  = q.sck;
    assign ack  = q.ack;
    assign done = q.done;

    // done is a single-cycle pulse (R3)
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // enable is low whenever done is reported (R4)
    assert_done_drops_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !en);
    // enable only rises while the divisor was legal (R5)
    assert_enable_needs_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> $past(legal));
    // a fault clears enable on the next cycle and suppresses done (R7)
    assert_fault_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_fault |=> (!en && !done));
    // idle clock follows polarity with one cycle of delay (R8)
    assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !busy && !$past(busy)) |-> (sck == $past(cpol)));
    // an acknowledge only follows an enabled, idle state (R9)
    assert_ack_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> ($past(en) && !$past(busy) && busy));
endmodule

// File: rtl/sckgen_top.sv
`timescale 1ns/1ps
module sckgen_top
    import sckgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_wr,
    input  logic [DIV_W-1:0]  div_wdata,
    input  logic              en_set,
    input  logic              cpol,
    input  logic              mode_fault,
    input  logic              xfer_req,
    input  logic [BITS_W-1:0] xfer_bits,
    output logic              xfer_ack,
    output logic              enable,
    output logic              sck,
    output logic              done
);
    logic [DIV_W-1:0] div_val;
    logic             div_ok;
    logic             start;
    logic             busy;
    logic             tick;

    sckgen_divreg #(.W(DIV_W), .RST_V(DIV_RESET)) u_divreg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (div_wr),
        .wdata (div_wdata),
        .div   (div_val),
        .legal (div_ok)
    );

    sckgen_halfcnt #(.W(DIV_W)) u_halfcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start),
        .run   (busy),
        .div   (div_val),
        .tick  (tick)
    );

    sckgen_ctrl #(.BW(BITS_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_set     (en_set),
        .legal      (div_ok),
        .cpol       (cpol),
        .mode_fault (mode_fault),
        .req        (xfer_req),
        .bits       (xfer_bits),
        .tick       (tick),
        .start      (start),
        .busy       (busy),
        .en         (enable),
        .sck        (sck),
        .ack        (xfer_ack),
        .done       (done)
    );
endmodule

// File: tb/sckgen_top_bench.sv
`timescale 1ns/1ps
module sckgen_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_wr = 1'b0;
    logic [7:0] div_wdata = '0;
    logic       en_set = 1'b0;
    logic       cpol = 1'b0;
    logic       mode_fault = 1'b0;
    logic       xfer_req = 1'b0;
    logic [4:0] xfer_bits = '0;
    logic       xfer_ack, enable, sck, done;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    sckgen_top u_sckgen_top (
        .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_wdata(div_wdata),
        .en_set(en_set), .cpol(cpol), .mode_fault(mode_fault),
        .xfer_req(xfer_req), .xfer_bits(xfer_bits), .xfer_ack(xfer_ack),
        .enable(enable), .sck(sck), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_div(input int v);
        @(negedge clk); div_wr = 1'b1; div_wdata = 8'(v);
        @(negedge clk); div_wr = 1'b0;
    endtask

    task automatic arm();
        @(negedge clk); en_set = 1'b1;
        @(negedge clk); en_set = 1'b0;
    endtask

    // start a transfer and return once the acknowledge is sampled
    task automatic request(input int bits, output bit got);
        got = 1'b0;
        @(negedge clk); xfer_req = 1'b1; xfer_bits = 5'(bits);
        for (int i = 0; i < 8 && !got; i++) begin
            @(negedge clk);
            if (xfer_ack) got = 1'b1;
        end
        xfer_req = 1'b0;
    endtask

    // time every edge; first n_a half-periods expect a, later ones expect b
    task automatic measure(input string tag, input int bits, input int a, input int b,
                           input int n_a, input int new_div, input int wr_edge);
        bit prev;
        prev = sck;
        for (int e = 0; e < 2 * bits; e++) begin
            int cnt = 0;
            do begin
                @(negedge clk);
                div_wr = 1'b0;
                cnt++;
            end while (sck == prev && cnt < 600);
            chk(cnt == ((e < n_a) ? a : b), {tag, " half-period"}, cnt, (e < n_a) ? a : b);
            prev = sck;
            if (e == 2 * bits - 1) begin
                chk(done == 1'b1, {tag, " R3 done at last edge"}, done, 1);
                chk(enable == 1'b0, {tag, " R4 enable cleared"}, enable, 0);
                chk(sck == cpol, {tag, " R3 idle level"}, sck, cpol);
            end else begin
                chk(done == 1'b0, {tag, " R3 no early done"}, done, 0);
            end
            if (wr_edge != 0 && e == wr_edge - 1) begin
                div_wr = 1'b1; div_wdata = 8'(new_div);
            end
        end
        @(negedge clk);
        chk(done == 1'b0, {tag, " R3 done one cycle"}, done, 0);
        chk(sck == cpol, {tag, " R3 stays idle"}, sck, cpol);
    endtask

    task automatic t_reset();
        chk(enable == 1'b0, "R1 reset enable", enable, 0);
        chk(sck == 1'b0, "R1 reset sck", sck, 0);
        chk(done == 1'b0, "R1 reset done", done, 0);
        chk(xfer_ack == 1'b0, "R1 reset ack", xfer_ack, 0);
    endtask

    task automatic t_default_div();
        bit got;
        arm();
        chk(enable == 1'b1, "R1 enable set", enable, 1);
        request(3, got);
        chk(got, "R9 ack seen", got, 1);
        measure("R1 R2 default div", 3, 4, 4, 6, 0, 0);
    endtask

    task automatic t_div2_cpol1();
        bit got;
        @(negedge clk); cpol = 1'b1;
        write_div(2);
        arm();
        request(2, got);
        chk(got, "R9 ack div2", got, 1);
        measure("R2 div2 cpol1", 2, 2, 2, 4, 0, 0);
        @(negedge clk); cpol = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_div255();
        bit got;
        write_div(255);
        arm();
        request(1, got);
        chk(got, "R9 ack div255", got, 1);
        measure("R2 div255", 1, 255, 255, 2, 0, 0);
    endtask

    task automatic t_illegal(input int v);
        bit moved = 1'b0;
        bit acked = 1'b0;
        write_div(v);
        arm();
        chk(enable == 1'b0, "R5 enable stays low", enable, 0);
        @(negedge clk); xfer_req = 1'b1; xfer_bits = 5'd2;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (xfer_ack) acked = 1'b1;
            if (sck != cpol) moved = 1'b1;
        end
        xfer_req = 1'b0;
        chk(!acked, "R5 no ack with illegal divisor", acked, 0);
        chk(!moved, "R5 no sck edges", moved, 0);
    endtask

    task automatic t_midwrite();
        bit got;
        write_div(3);
        arm();
        request(4, got);
        chk(got, "R9 ack midwrite", got, 1);
        measure("R6 divisor change", 4, 3, 6, 2, 6, 1);
    endtask

    task automatic t_fault();
        bit got;
        bit moved = 1'b0;
        bit dn = 1'b0;
        write_div(5);
        arm();
        request(4, got);
        for (int i = 0; i < 5; i++) @(negedge clk);
        chk(sck == 1'b1, "R7 first edge reached", sck, 1);
        mode_fault = 1'b1;
        @(negedge clk); mode_fault = 1'b0;
        chk(enable == 1'b0, "R7 fault clears enable", enable, 0);
        chk(sck == cpol, "R7 sck idle after fault", sck, cpol);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (sck != cpol) moved = 1'b1;
            if (done) dn = 1'b1;
        end
        chk(!moved && !dn, "R7 no further edges or done", moved | dn, 0);
    endtask

    task automatic t_illegal_abort();
        bit got;
        bit dn = 1'b0;
        write_div(5);
        arm();
        request(3, got);
        for (int i = 0; i < 5; i++) @(negedge clk);
        div_wr = 1'b1; div_wdata = 8'd0;
        @(negedge clk); div_wr = 1'b0;
        if (done) dn = 1'b1;
        @(negedge clk);
        if (done) dn = 1'b1;
        chk(enable == 1'b0, "R10 abort clears enable", enable, 0);
        chk(sck == cpol, "R10 sck idle after abort", sck, cpol);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (done) dn = 1'b1;
        end
        chk(!dn, "R10 no done after abort", dn, 0);
        write_div(4);
    endtask

    task automatic t_cpol_follow();
        @(negedge clk); cpol = 1'b1;
        @(negedge clk);
        chk(sck == 1'b1, "R8 idle follows cpol high", sck, 1);
        cpol = 1'b0;
        @(negedge clk);
        chk(sck == 1'b0, "R8 idle follows cpol low", sck, 0);
    endtask

    task automatic t_zero_bits();
        bit acked = 1'b0;
        arm();
        @(negedge clk); xfer_req = 1'b1; xfer_bits = 5'd0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (xfer_ack) acked = 1'b1;
        end
        xfer_req = 1'b0;
        chk(!acked, "R9 zero-bit request ignored", acked, 0);
        chk(enable == 1'b1, "R9 enable kept", enable, 1);
        mode_fault = 1'b1;
        @(negedge clk); mode_fault = 1'b0;
        chk(enable == 1'b0, "R7 fault clears idle enable", enable, 0);
    endtask

    task automatic t_req_disabled();
        bit acked = 1'b0;
        @(negedge clk); xfer_req = 1'b1; xfer_bits = 5'd2;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (xfer_ack) acked = 1'b1;
        end
        xfer_req = 1'b0;
        chk(!acked, "R9 no ack while disabled", acked, 0);
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default_div();
        t_req_disabled();
        t_div2_cpol1();
        t_div255();
        t_illegal(1);
        t_illegal(0);
        t_midwrite();
        t_fault();
        t_illegal_abort();
        t_cpol_follow();
        t_zero_bits();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule